// File: doc/BRIEF.md
# Keypad Event Queue with Indexed Peek

This block buffers key press and key release events from a keypad scanner until a host collects them. Each event is packed into one byte and appended to a sixteen-entry circular queue that tracks a head position and an occupancy count. A host can collect events in two ways. A consuming read moves the head forward and then returns the entry it lands on. A peek returns the entry at a chosen offset from the head and leaves the queue as it is.

Two interrupt-style flags tell the host that something needs attention. The keypad flag means at least one event was accepted. The error flag means an event arrived while the queue was full. A one-cycle pulse marks the moment the overflow happens. While the error flag is set, new events are dropped silently. An acknowledge input clears both flags. A flush input empties the queue.

Top module: `key_event_queue`

## Requirements
- R1: The queue holds 16 one-byte entries in a circular store. Entry positions wrap modulo 16, both for appends and for offsets counted from the head.
- R2: An accepted event is stored as the byte {evt_pressed, evt_code[6:0]}. Bit 7 is 1 for a press and 0 for a release.
- R3: An event that arrives when the queue already holds 16 entries is not stored. `ovf_pulse` is high for exactly the one cycle after that clock edge, and `err_flag` becomes 1.
- R4: While `err_flag` is 1, arriving events are discarded with no pulse and no change to the queue. Asserting `flag_ack` clears `err_flag`, and events are accepted again afterwards.
- R5: A consuming read (`pop_req`) with 0 or 1 entries stored returns 0x00 and changes nothing. With 2 or more entries it advances the head by one modulo 16, decrements the count, and returns the entry at the new head. `rd_data` shows the result in the cycle after the request.
- R6: A peek (`peek_req`) at offset k returns the entry at (head + k) mod 16 when k is less than the count, and 0x00 otherwise. It leaves the head and the count unchanged. If a peek and a consuming read arrive together, the read is served.
- R7: Every accepted event sets `kbd_flag`. `flag_ack` clears it, but an event accepted in the same cycle as the acknowledge leaves the flag set.
- R8: `flush` sets the head and the count to zero and clears both flags. It takes precedence over any event or read presented in the same cycle.
- R9: If an event and a consuming read arrive in the same cycle, the read is applied first and the event is appended after it. A full queue therefore accepts the event without an overflow.
- R10: Synchronous active-low reset clears the head, the count, every entry, both flags, the pulse and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | A key event is present this cycle |
| evt_code | input | 7 | Key code of the event |
| evt_pressed | input | 1 | 1 for a press, 0 for a release |
| pop_req | input | 1 | Consuming read request |
| peek_req | input | 1 | Non-destructive read request |
| peek_idx | input | IDX_W (8) | Offset from the head for a peek |
| flush | input | 1 | Empty the queue and clear the flags |
| flag_ack | input | 1 | Clear the keypad and error flags |
| rd_data | output | 8 | Result of the last read request |
| kbd_flag | output | 1 | An event has been accepted since the last clear |
| err_flag | output | 1 | An overflow is pending |
| ovf_pulse | output | 1 | One-cycle marker of a refused push |

## Verification
On every cycle, the assertions check several properties:
- the count never exceeds the depth;
- a short consuming read leaves the pointers alone, and a long one moves the head by one;
- a peek disturbs nothing;
- a flush returns the pointers to zero;
- a pending error blocks any change to the count;
- an overflow pulse never appears without the error flag;
- an accepted push is always followed by the keypad flag.

The stored byte values cannot be covered that way, so only the bench's scenarios show them. These include the wrap of offsets past entry 15, the entry that survives a refused push, and the ordering of a read and a push that arrive in the same cycle.

// File: rtl/key_event_queue_pkg.sv
// Shared definitions for the keypad event queue.
// Assumes an entry is one byte: a 7-bit key code plus a press bit on top.
package key_event_queue_pkg;

    localparam int CODE_W  = 7;
    localparam int ENTRY_W = CODE_W + 1;

    typedef logic [ENTRY_W-1:0] entry_t;

    // Pack a key code and its press state into one stored entry.
    function automatic entry_t pack_entry(input logic [CODE_W-1:0] code,
                                          input logic pressed);
        return {pressed, code};
    endfunction

endpackage

// File: rtl/keyq_ptrs.sv
// Head and occupancy control for the circular event queue.
// A consuming read is applied before a push in the same cycle, and flush
// overrides both. Assumes DEPTH is a power of two, so that address
// arithmetic wraps naturally.
module keyq_ptrs #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_valid,
    input  logic          pop_req,
    input  logic          flush,
    input  logic          discard,
    output logic [AW-1:0] head,
    output logic [LW-1:0] len,
    output logic          pop_go,
    output logic          push_acc,
    output logic          push_ovf,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] pop_addr
);

    localparam logic [LW-1:0] FULL_LEN = LW'(DEPTH);

    logic [AW-1:0] head_a;
    logic [LW-1:0] len_a;
    logic          push_try;

    // Work out the post-read pointers, then decide whether the push fits.
    always_comb begin
        pop_go   = pop_req && !flush && (len > LW'(1));
        head_a   = pop_go ? head + AW'(1) : head;
        len_a    = pop_go ? len - LW'(1) : len;
        push_try = evt_valid && !flush && !discard;
        push_acc = push_try && (len_a < FULL_LEN);
        push_ovf = push_try && (len_a == FULL_LEN);
        wr_addr  = head_a + len_a[AW-1:0];
        pop_addr = head + AW'(1);
    end

    // Register the head and the count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head <= '0;
            len  <= '0;
        end else begin
            head <= head_a;
            len  <= len_a + LW'(push_acc);
        end
    end

    // R1
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len <= FULL_LEN);

    // R5
    pop_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !flush && !evt_valid && len <= LW'(1)) |=> ($stable(len) && $stable(head)));

    // R5
    pop_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !flush && len > LW'(1)) |=> (head == $past(head) + AW'(1)));

    // R4
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && discard && !pop_req && !flush) |=> $stable(len));

    // R8
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (len == '0 && head == '0));

endmodule

// File: rtl/keyq_store.sv
// Entry storage for the event queue: one write port and two
// combinational read ports. All entries are cleared on reset.
module keyq_store
    import key_event_queue_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  entry_t        wr_data,
    input  logic [AW-1:0] ra_addr,
    output entry_t        ra_data,
    input  logic [AW-1:0] rb_addr,
    output entry_t        rb_data
);

    entry_t mem [DEPTH];

    // Clear all entries on reset, otherwise store the accepted entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Serve the two read addresses from the current contents.
    always_comb begin
        ra_data = mem[ra_addr];
        rb_data = mem[rb_addr];
    end

endmodule

// File: rtl/keyq_flags.sv
// Keypad and error flags, plus the overflow pulse.
// A new event outranks an acknowledge in the same cycle, and flush
// clears everything.
module keyq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic flag_ack,
    input  logic push_acc,
    input  logic push_ovf,
    output logic kbd_flag,
    output logic err_flag,
    output logic ovf_pulse
);

    // Update the sticky flags and the one-cycle overflow marker.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            kbd_flag  <= 1'b0;
            err_flag  <= 1'b0;
            ovf_pulse <= 1'b0;
        end else begin
            kbd_flag  <= push_acc | (kbd_flag & ~flag_ack);
            err_flag  <= push_ovf | (err_flag & ~flag_ack);
            ovf_pulse <= push_ovf;
        end
    end

    // R3
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> err_flag);

    // R4
    no_repeat_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> !ovf_pulse);

    // R7
    kbd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_acc && !flush) |=> kbd_flag);

endmodule

// File: rtl/key_event_queue.sv
// Top of the keypad event queue. It ties together the pointer control,
// the entry store and the flags, and registers the byte returned by
// consuming reads and peeks. A consuming read outranks a peek in the
// same cycle. rd_data holds its value until the next read request.
module key_event_queue
    import key_event_queue_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic [CODE_W-1:0]  evt_code,
    input  logic               evt_pressed,
    input  logic               pop_req,
    input  logic               peek_req,
    input  logic [IDX_W-1:0]   peek_idx,
    input  logic               flush,
    input  logic               flag_ack,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               kbd_flag,
    output logic               err_flag,
    output logic               ovf_pulse
);

    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;
    localparam int XW = IDX_W + LW;

    logic [AW-1:0] head, wr_addr, pop_addr, peek_addr;
    logic [LW-1:0] len;
    logic          pop_go, push_acc, push_ovf, peek_in;
    entry_t        pop_data, peek_data, new_entry;

    keyq_ptrs #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) ptrs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_valid(evt_valid),
        .pop_req  (pop_req),
        .flush    (flush),
        .discard  (err_flag),
        .head     (head),
        .len      (len),
        .pop_go   (pop_go),
        .push_acc (push_acc),
        .push_ovf (push_ovf),
        .wr_addr  (wr_addr),
        .pop_addr (pop_addr)
    );

    // Build the stored byte and the peek address and range test.
    always_comb begin
        new_entry = pack_entry(evt_code, evt_pressed);
        peek_addr = head + peek_idx[AW-1:0];
        peek_in   = XW'(peek_idx) < XW'(len);
    end

    keyq_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (push_acc),
        .wr_addr(wr_addr),
        .wr_data(new_entry),
        .ra_addr(pop_addr),
        .ra_data(pop_data),
        .rb_addr(peek_addr),
        .rb_data(peek_data)
    );

    keyq_flags flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .flag_ack (flag_ack),
        .push_acc (push_acc),
        .push_ovf (push_ovf),
        .kbd_flag (kbd_flag),
        .err_flag (err_flag),
        .ovf_pulse(ovf_pulse)
    );

    // Register the byte answered by this cycle's read request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (pop_req && !flush) begin
            rd_data <= pop_go ? pop_data : '0;
        end else if (peek_req && !flush) begin
            rd_data <= peek_in ? peek_data : '0;
        end
    end

    // R6
    peek_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_req && !pop_req && !evt_valid && !flush) |=> ($stable(head) && $stable(len)));

    // R6
    peek_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_req && !pop_req && !flush && !peek_in) |=> (rd_data == '0));

endmodule

// File: tb/key_event_queue_tb_top.sv
// Self-checking bench: a table of push, pop and peek steps, followed by
// directed tests for reset, flags, flush, overflow, wrap and ordering.
module key_event_queue_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    localparam logic [1:0] OP_PUSH = 2'd0, OP_POP = 2'd1, OP_PEEK = 2'd2;

    // Each entry holds {op, arg, expected}; arg is the pushed byte or the peek offset.
    localparam logic [17:0] VEC [NVEC] = '{
        {OP_PUSH, 8'h85, 8'h00},
        {OP_PUSH, 8'h3C, 8'h00},
        {OP_PUSH, 8'h91, 8'h00},
        {OP_PEEK, 8'd0,  8'h85},
        {OP_PEEK, 8'd2,  8'h91},
        {OP_PEEK, 8'd3,  8'h00},
        {OP_POP,  8'd0,  8'h3C},
        {OP_PEEK, 8'd0,  8'h3C},
        {OP_POP,  8'd0,  8'h91},
        {OP_POP,  8'd0,  8'h00},
        {OP_PEEK, 8'd0,  8'h91},
        {OP_PEEK, 8'd1,  8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_valid = 1'b0, evt_pressed = 1'b0;
    logic [6:0] evt_code = '0;
    logic       pop_req = 1'b0, peek_req = 1'b0, flush = 1'b0, flag_ack = 1'b0;
    logic [7:0] peek_idx = '0;
    logic [7:0] rd_data;
    logic       kbd_flag, err_flag, ovf_pulse;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    key_event_queue dut_i (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_pressed(evt_pressed),
        .pop_req(pop_req), .peek_req(peek_req), .peek_idx(peek_idx),
        .flush(flush), .flag_ack(flag_ack),
        .rd_data(rd_data), .kbd_flag(kbd_flag), .err_flag(err_flag), .ovf_pulse(ovf_pulse)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Present one cycle of stimulus, let the edge pass, then release the inputs.
    task automatic step(input logic push, input logic [7:0] byt, input logic pop,
                        input logic peek, input logic [7:0] idx,
                        input logic fl, input logic ack);
        evt_valid   = push;
        evt_code    = byt[6:0];
        evt_pressed = byt[7];
        pop_req     = pop;
        peek_req    = peek;
        peek_idx    = idx;
        flush       = fl;
        flag_ack    = ack;
        @(posedge clk);
        #1;
        evt_valid = 1'b0; pop_req = 1'b0; peek_req = 1'b0;
        flush = 1'b0; flag_ack = 1'b0;
    endtask

    task automatic peek_chk(input string req, input logic [7:0] idx, input logic [7:0] exp);
        step(1'b0, 8'h00, 1'b0, 1'b1, idx, 1'b0, 1'b0);
        chk(req, rd_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 rd_data", rd_data, 8'h00);
        chk("R10 kbd_flag", {7'd0, kbd_flag}, 8'h00);
        chk("R10 err_flag", {7'd0, err_flag}, 8'h00);
        chk("R10 ovf_pulse", {7'd0, ovf_pulse}, 8'h00);
        peek_chk("R10 empty peek", 8'd0, 8'h00);

        // R2 R5 R6: table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            logic [7:0] arg, exp;
            {op, arg, exp} = VEC[i];
            if (op == OP_PUSH) begin
                step(1'b1, arg, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
            end else if (op == OP_POP) begin
                step(1'b0, 8'h00, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0);
                chk($sformatf("R5 pop step %0d", i), rd_data, exp);
            end else begin
                step(1'b0, 8'h00, 1'b0, 1'b1, arg, 1'b0, 1'b0);
                chk($sformatf("R6 R2 peek step %0d", i), rd_data, exp);
            end
        end

        // R7: flag set, acknowledge, set outranks acknowledge
        chk("R7 kbd set", {7'd0, kbd_flag}, 8'h01);
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1);
        chk("R7 kbd ack", {7'd0, kbd_flag}, 8'h00);
        step(1'b1, 8'h12, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1);
        chk("R7 set beats ack", {7'd0, kbd_flag}, 8'h01);

        // R8: flush empties the queue and clears the flags
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'd0, 1'b1, 1'b0);
        chk("R8 kbd cleared", {7'd0, kbd_flag}, 8'h00);
        peek_chk("R8 empty after flush", 8'd0, 8'h00);

        // R3: fill to 16, then overflow
        for (int i = 0; i < 16; i++) step(1'b1, 8'h80 | 8'(i), 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
        chk("R3 no pulse when filling", {7'd0, ovf_pulse}, 8'h00);
        step(1'b1, 8'h55, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
        chk("R3 ovf pulse", {7'd0, ovf_pulse}, 8'h01);
        chk("R3 err flag", {7'd0, err_flag}, 8'h01);
        peek_chk("R3 pulse one cycle (peek 15)", 8'd15, 8'h8F);
        chk("R3 pulse dropped", {7'd0, ovf_pulse}, 8'h00);
        peek_chk("R3 head entry intact", 8'd0, 8'h80);
        peek_chk("R6 offset 16 out of range", 8'd16, 8'h00);

        // R4: discard while error pending
        step(1'b1, 8'h66, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
        chk("R4 no pulse while pending", {7'd0, ovf_pulse}, 8'h00);
        peek_chk("R4 queue untouched", 8'd0, 8'h80);
        step(1'b0, 8'h00, 1'b0, 1'b0, 8'd0, 1'b0, 1'b1);
        chk("R4 ack clears err", {7'd0, err_flag}, 8'h00);

        // R5 R1: consume, then push that wraps to entry 0
        step(1'b0, 8'h00, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0);
        chk("R5 pop after fill", rd_data, 8'h81);
        step(1'b1, 8'h7F, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0);
        chk("R4 push accepted after ack", {7'd0, ovf_pulse}, 8'h00);
        peek_chk("R1 wrapped entry", 8'd15, 8'h7F);
        peek_chk("R1 entry before wrap", 8'd14, 8'h8F);

        // R9: consume and push together while full
        step(1'b1, 8'h33, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0);
        chk("R9 pop data", rd_data, 8'h82);
        chk("R9 no overflow", {7'd0, ovf_pulse}, 8'h00);
        peek_chk("R9 pushed entry at tail", 8'd15, 8'h33);
        peek_chk("R9 wrap entry shifted", 8'd14, 8'h7F);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule